// File: doc/BRIEF.md
# Victim Writeback Acceptance Controller

This block sits in front of a small shared second-level cache and manages, line by line, the coherence state of what it holds. Upper-level caches evict lines into it by sending a victim request (dirty or clean, each with a shared hint). The controller acknowledges the victim at once, remembers who sent it, and parks the line in a wait that records the prior stable state, the victim kind and the shared hint. A later data message (carrying its own shared flag) or a stale notice from the same sender closes the wait. The controller then picks the new stable state and reports it to the directory as an unblock.

The same request channel carries reads. A plain or shared read that hits returns data and demotes the line. A read-for-modify that hits an exclusive-rights line hands the line over and drops it. Anything the cache cannot serve is passed on to the directory. The tag, state, dirty and data arrays form a direct-mapped register file of `NSETS` lines. Only one victim wait is open at a time.

Top module: `vwb_top`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high and `ack_valid`, `dat_valid`, `fwd_valid`, `unb_valid`, `repl_valid` and `proto_err` are low. A read-for-modify to any address is therefore forwarded.
- R2: A victim request is either dirty (`req_kind`=3) or clean (`req_kind`=4). When one is accepted, `ack_valid` pulses in the cycle after acceptance, with `ack_dst` equal to `req_src`. An accepted request never produces both an acknowledgement and a forward.
- R3: From invalid (`rsp_stale`=0), the data message fixes the final state as follows. A dirty victim ends modified, or owned if the victim hint or the data's `rsp_shared` is set. A clean victim ends exclusive, or shared if either flag is set.
- R4: From a valid prior state, data for a victim whose tag matches leaves exclusive, owned and modified unchanged. A shared line becomes owned only for a dirty victim with the shared hint; otherwise it stays shared.
- R5: A stale notice (`rsp_stale`=1) from the recorded sender ends the wait with the line back in its prior state and its data and dirty bit untouched. An invalid-origin line stays invalid.
- R6: Each wait that ends produces one `unb_valid` pulse one cycle after the message. The flag pair {`unb_owner`,`unb_live`} is {1,1} for modified, owned or exclusive, {0,1} for shared and {0,0} for invalid.
- R7: A data message replaces the line data. The dirty bit becomes old-dirty OR `rsp_dirty`, so clean data never clears it. From invalid the old dirty bit counts as 0.
- R8: A plain read (`req_kind`=0) or shared read (1) that hits modified or owned returns data with `dat_excl`=0 and leaves the line owned. A hit on exclusive or shared returns the same and leaves the line shared.
- R9: A read-for-modify (2) that hits modified or exclusive returns data with `dat_excl`=1 and the line's dirty bit, then invalidates the line. A read-for-modify on owned, shared or invalid lines, any miss, and kinds 5 to 7 are forwarded.
- R10: A forwarded request shows on `fwd_*` in the cycle after acceptance. Read data shows on `dat_*` `RSP_LAT` cycles after acceptance, counting the first cycle after acceptance as cycle 1.
- R11: A victim whose set holds a valid line with another tag is held (`req_ready` low). In the following cycle `repl_valid` is high and `repl_addr` names the resident line. Once the set is free the victim is accepted.
- R12: While a wait is open, any request to its set and any further victim is held. Reads to other sets are served, even in the same cycle in which the data message closes the wait.
- R13: A data or stale message whose `rsp_src` differs from the recorded sender, or that arrives with no wait open, pulses `proto_err` one cycle later and is otherwise ignored. The wait stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | request taken at this edge |
| req_kind | input | 3 | 0 read, 1 shared read, 2 read-for-modify, 3 dirty victim, 4 clean victim |
| req_shared | input | 1 | shared hint of a victim |
| req_addr | input | AW | line address, low IW bits select the set |
| req_src | input | SW | requester id |
| rsp_valid | input | 1 | data or stale message present |
| rsp_ready | output | 1 | always high |
| rsp_stale | input | 1 | 1: stale notice, 0: data |
| rsp_shared | input | 1 | shared flag of the data |
| rsp_dirty | input | 1 | data is dirty |
| rsp_src | input | SW | sender id |
| rsp_data | input | DW | line data |
| ack_valid | output | 1 | writeback acknowledgement |
| ack_dst | output | SW | its destination |
| dat_valid | output | 1 | read data response |
| dat_dst | output | SW | its destination |
| dat_data | output | DW | line data |
| dat_dirty | output | 1 | line dirty bit |
| dat_excl | output | 1 | 1: modify rights handed over |
| fwd_valid | output | 1 | request passed to directory |
| fwd_kind | output | 3 | its kind |
| fwd_addr | output | AW | its address |
| fwd_src | output | SW | original requester |
| unb_valid | output | 1 | unblock to directory |
| unb_owner | output | 1 | line now held as owner |
| unb_live | output | 1 | line now valid |
| repl_valid | output | 1 | held victim needs a replacement |
| repl_addr | output | AW | line to replace |
| proto_err | output | 1 | unexpected message seen |

## Verification
The case that needs care is a read hit on one set accepted in the same cycle as the data message that closes the victim wait on another set. Both then write the state array in one cycle. The bench drives both inputs together on one edge. It checks the unblock flags of the finished victim, the delayed read data of the other line, and afterwards the states both lines were left in, probed by read-for-modify. A full sweep covers every prior state, victim kind, hint and closing message, and each case is judged against a state model built from the requirements.

// File: rtl/vwb_pkg.sv
package vwb_pkg;

  typedef enum logic [2:0] {
    LS_I = 3'd0,
    LS_S = 3'd1,
    LS_E = 3'd2,
    LS_O = 3'd3,
    LS_M = 3'd4
  } line_st_t;

  localparam logic [2:0] RK_READ      = 3'd0;
  localparam logic [2:0] RK_READ_SH   = 3'd1;
  localparam logic [2:0] RK_READ_MOD  = 3'd2;
  localparam logic [2:0] RK_VIC_DIRTY = 3'd3;
  localparam logic [2:0] RK_VIC_CLEAN = 3'd4;

  // New stable state once victim data lands.
  function automatic line_st_t settle_state(line_st_t prior, logic vic_dirty,
                                            logic vic_sh, logic dat_sh);
    line_st_t r;
    case (prior)
      LS_I: begin
        if (vic_dirty) r = (vic_sh || dat_sh) ? LS_O : LS_M;
        else           r = (vic_sh || dat_sh) ? LS_S : LS_E;
      end
      LS_S:    r = (vic_dirty && vic_sh) ? LS_O : LS_S;
      default: r = prior;
    endcase
    return r;
  endfunction

  // {owner, valid} flags reported to the directory.
  function automatic logic [1:0] unblock_code(line_st_t s);
    logic [1:0] r;
    case (s)
      LS_M, LS_O, LS_E: r = 2'b11;
      LS_S:             r = 2'b01;
      default:          r = 2'b00;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vwb_line_store.sv
module vwb_line_store
  import vwb_pkg::*;
#(
  parameter int NSETS = 8,
  parameter int TW    = 5,
  parameter int DW    = 16,
  localparam int IW   = $clog2(NSETS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  output line_st_t      ra_state,
  output logic [TW-1:0] ra_tag,
  output logic          ra_dirty,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic          rb_dirty,
  input  logic          wa_en,
  input  logic [IW-1:0] wa_idx,
  input  line_st_t      wa_state,
  input  logic [TW-1:0] wa_tag,
  input  logic          wa_clr,
  input  logic          wb_en,
  input  logic [IW-1:0] wb_idx,
  input  line_st_t      wb_state,
  input  logic          wb_dirty,
  input  logic          wb_den,
  input  logic [DW-1:0] wb_data
);

  line_st_t      st_q  [NSETS];
  logic          dty_q [NSETS];
  logic [TW-1:0] tag_q [NSETS];
  logic [DW-1:0] dat_q [NSETS];

  // state and dirty bits need a reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSETS; i++) begin
        st_q[i]  <= LS_I;
        dty_q[i] <= 1'b0;
      end
    end else begin
      if (wa_en) begin
        st_q[wa_idx] <= wa_state;
        if (wa_clr) dty_q[wa_idx] <= 1'b0;
      end
      if (wb_en) begin
        st_q[wb_idx]  <= wb_state;
        dty_q[wb_idx] <= wb_dirty;
      end
    end
  end

  // tag and data arrays carry no reset
  always_ff @(posedge clk) begin
    if (wa_en)  tag_q[wa_idx] <= wa_tag;
    if (wb_den) dat_q[wb_idx] <= wb_data;
  end

  assign ra_state = st_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_dirty = dty_q[ra_idx];
  assign ra_data  = dat_q[ra_idx];
  assign rb_dirty = dty_q[rb_idx];

endmodule

// File: rtl/vwb_delay.sv
module vwb_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  logic         v_q [DEPTH];
  logic [W-1:0] d_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) v_q[i] <= 1'b0;
    end else begin
      v_q[0] <= in_v;
      for (int i = 1; i < DEPTH; i++) v_q[i] <= v_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    d_q[0] <= in_d;
    for (int i = 1; i < DEPTH; i++) d_q[i] <= d_q[i-1];
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];

endmodule

// File: rtl/vwb_top.sv
module vwb_top
  import vwb_pkg::*;
#(
  parameter int NSETS   = 8,
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int SW      = 4,
  parameter int RSP_LAT = 20,
  localparam int IW     = $clog2(NSETS),
  localparam int TW     = AW - IW,
  localparam int PW     = SW + DW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic          req_shared,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_src,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          rsp_stale,
  input  logic          rsp_shared,
  input  logic          rsp_dirty,
  input  logic [SW-1:0] rsp_src,
  input  logic [DW-1:0] rsp_data,
  output logic          ack_valid,
  output logic [SW-1:0] ack_dst,
  output logic          dat_valid,
  output logic [SW-1:0] dat_dst,
  output logic [DW-1:0] dat_data,
  output logic          dat_dirty,
  output logic          dat_excl,
  output logic          fwd_valid,
  output logic [2:0]    fwd_kind,
  output logic [AW-1:0] fwd_addr,
  output logic [SW-1:0] fwd_src,
  output logic          unb_valid,
  output logic          unb_owner,
  output logic          unb_live,
  output logic          repl_valid,
  output logic [AW-1:0] repl_addr,
  output logic          proto_err
);

  logic [IW-1:0] r_idx;
  logic [TW-1:0] r_tag;
  assign r_idx = req_addr[IW-1:0];
  assign r_tag = req_addr[AW-1:IW];

  line_st_t      ra_state;
  logic [TW-1:0] ra_tag;
  logic          ra_dirty;
  logic [DW-1:0] ra_data;
  logic          rb_dirty;

  // the one open victim wait
  logic          busy_q;
  logic [IW-1:0] pidx_q;
  line_st_t      pprior_q;
  logic          pvd_q, pvsh_q;
  logic [SW-1:0] psrc_q;

  logic is_vic, line_hit, set_free, pend_clash, take;
  assign is_vic     = (req_kind == RK_VIC_DIRTY) || (req_kind == RK_VIC_CLEAN);
  assign line_hit   = (ra_state != LS_I) && (ra_tag == r_tag);
  assign set_free   = (ra_state == LS_I) || (ra_tag == r_tag);
  assign pend_clash = busy_q && (r_idx == pidx_q);
  assign req_ready  = !pend_clash && (!is_vic || (!busy_q && set_free));
  assign take       = req_valid && req_ready;
  assign rsp_ready  = 1'b1;

  // request path
  logic     wa_en, wa_clr, d_in_v, d_excl, fwd_go;
  line_st_t wa_state;
  always_comb begin
    wa_en    = 1'b0;
    wa_clr   = 1'b0;
    wa_state = ra_state;
    d_in_v   = 1'b0;
    d_excl   = 1'b0;
    fwd_go   = 1'b0;
    if (take) begin
      if (is_vic) begin
        wa_en    = 1'b1;
        wa_state = line_hit ? ra_state : LS_I;
        wa_clr   = !line_hit;
      end else if ((req_kind == RK_READ) || (req_kind == RK_READ_SH)) begin
        if (line_hit) begin
          d_in_v   = 1'b1;
          wa_en    = 1'b1;
          wa_state = ((ra_state == LS_M) || (ra_state == LS_O)) ? LS_O : LS_S;
        end else begin
          fwd_go = 1'b1;
        end
      end else if ((req_kind == RK_READ_MOD) && line_hit &&
                   ((ra_state == LS_M) || (ra_state == LS_E))) begin
        d_in_v   = 1'b1;
        d_excl   = 1'b1;
        wa_en    = 1'b1;
        wa_state = LS_I;
        wa_clr   = 1'b1;
      end else begin
        fwd_go = 1'b1;
      end
    end
  end

  // completion path
  logic     rsp_ok, wb_dirty, wb_den;
  line_st_t fin;
  assign rsp_ok   = rsp_valid && busy_q && (rsp_src == psrc_q);
  assign fin      = rsp_stale ? pprior_q : settle_state(pprior_q, pvd_q, pvsh_q, rsp_shared);
  assign wb_dirty = rsp_stale ? rb_dirty : (rb_dirty | rsp_dirty);
  assign wb_den   = rsp_ok && !rsp_stale;

  vwb_line_store #(.NSETS(NSETS), .TW(TW), .DW(DW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .ra_idx   (r_idx),
    .ra_state (ra_state),
    .ra_tag   (ra_tag),
    .ra_dirty (ra_dirty),
    .ra_data  (ra_data),
    .rb_idx   (pidx_q),
    .rb_dirty (rb_dirty),
    .wa_en    (wa_en),
    .wa_idx   (r_idx),
    .wa_state (wa_state),
    .wa_tag   (r_tag),
    .wa_clr   (wa_clr),
    .wb_en    (rsp_ok),
    .wb_idx   (pidx_q),
    .wb_state (fin),
    .wb_dirty (wb_dirty),
    .wb_den   (wb_den),
    .wb_data  (rsp_data)
  );

  logic [PW-1:0] pay_out;
  vwb_delay #(.W(PW), .DEPTH(RSP_LAT)) u_dly (
    .clk   (clk),
    .rst   (rst),
    .in_v  (d_in_v),
    .in_d  ({req_src, ra_data, ra_dirty, d_excl}),
    .out_v (dat_valid),
    .out_d (pay_out)
  );
  assign {dat_dst, dat_data, dat_dirty, dat_excl} = pay_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      pidx_q     <= '0;
      pprior_q   <= LS_I;
      pvd_q      <= 1'b0;
      pvsh_q     <= 1'b0;
      psrc_q     <= '0;
      ack_valid  <= 1'b0;
      ack_dst    <= '0;
      fwd_valid  <= 1'b0;
      fwd_kind   <= '0;
      fwd_addr   <= '0;
      fwd_src    <= '0;
      unb_valid  <= 1'b0;
      unb_owner  <= 1'b0;
      unb_live   <= 1'b0;
      repl_valid <= 1'b0;
      repl_addr  <= '0;
      proto_err  <= 1'b0;
    end else begin
      ack_valid  <= take && is_vic;
      ack_dst    <= req_src;
      fwd_valid  <= fwd_go;
      fwd_kind   <= req_kind;
      fwd_addr   <= req_addr;
      fwd_src    <= req_src;
      unb_valid  <= rsp_ok;
      {unb_owner, unb_live} <= unblock_code(fin);
      proto_err  <= rsp_valid && !rsp_ok;
      repl_valid <= req_valid && is_vic && !busy_q && !set_free;
      repl_addr  <= {ra_tag, r_idx};
      if (take && is_vic) begin
        busy_q   <= 1'b1;
        pidx_q   <= r_idx;
        pprior_q <= line_hit ? ra_state : LS_I;
        pvd_q    <= (req_kind == RK_VIC_DIRTY);
        pvsh_q   <= req_shared;
        psrc_q   <= req_src;
      end else if (rsp_ok) begin
        busy_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vwb_chk.sv
module vwb_chk
  import vwb_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_kind,
  input logic       rsp_valid,
  input logic       ack_valid,
  input logic       fwd_valid,
  input logic       unb_valid,
  input logic       repl_valid,
  input logic       proto_err
);

  // R2
  ack_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    ack_valid |-> $past(req_valid && req_ready &&
                        ((req_kind == RK_VIC_DIRTY) || (req_kind == RK_VIC_CLEAN))));

  // R2
  ack_fwd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_valid, fwd_valid}));

  // R10
  fwd_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> $past(req_valid && req_ready));

  // R6
  unb_after_msg_chk: assert property (@(posedge clk) disable iff (rst)
    unb_valid |-> $past(rsp_valid));

  // R13
  err_after_msg_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> ($past(rsp_valid) && !unb_valid));

  // R11
  repl_held_chk: assert property (@(posedge clk) disable iff (rst)
    repl_valid |-> $past(req_valid && !req_ready));

endmodule

bind vwb_top vwb_chk u_vwb_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_kind   (req_kind),
  .rsp_valid  (rsp_valid),
  .ack_valid  (ack_valid),
  .fwd_valid  (fwd_valid),
  .unb_valid  (unb_valid),
  .repl_valid (repl_valid),
  .proto_err  (proto_err)
);

// File: tb/vwb_top_bench.sv
module vwb_top_bench;
  import vwb_pkg::*;

  localparam int CLK_P   = 10;
  localparam int NSETS   = 8;
  localparam int AW      = 8;
  localparam int DW      = 16;
  localparam int SW      = 4;
  localparam int RSP_LAT = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          req_valid = 0, req_shared = 0;
  logic [2:0]    req_kind = 0;
  logic [AW-1:0] req_addr = 0;
  logic [SW-1:0] req_src = 0;
  logic          req_ready;
  logic          rsp_valid = 0, rsp_stale = 0, rsp_shared = 0, rsp_dirty = 0;
  logic [SW-1:0] rsp_src = 0;
  logic [DW-1:0] rsp_data = 0;
  logic          rsp_ready;
  logic          ack_valid, dat_valid, dat_dirty, dat_excl, fwd_valid;
  logic          unb_valid, unb_owner, unb_live, repl_valid, proto_err;
  logic [SW-1:0] ack_dst, dat_dst, fwd_src;
  logic [DW-1:0] dat_data;
  logic [2:0]    fwd_kind;
  logic [AW-1:0] fwd_addr, repl_addr;

  vwb_top #(.NSETS(NSETS), .AW(AW), .DW(DW), .SW(SW), .RSP_LAT(RSP_LAT)) u_vwb_top (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_shared(req_shared), .req_addr(req_addr), .req_src(req_src),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_stale(rsp_stale),
    .rsp_shared(rsp_shared), .rsp_dirty(rsp_dirty), .rsp_src(rsp_src), .rsp_data(rsp_data),
    .ack_valid(ack_valid), .ack_dst(ack_dst),
    .dat_valid(dat_valid), .dat_dst(dat_dst), .dat_data(dat_data),
    .dat_dirty(dat_dirty), .dat_excl(dat_excl),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_addr(fwd_addr), .fwd_src(fwd_src),
    .unb_valid(unb_valid), .unb_owner(unb_owner), .unb_live(unb_live),
    .repl_valid(repl_valid), .repl_addr(repl_addr), .proto_err(proto_err)
  );

  always #(CLK_P/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // event recorder, sampled on the falling edge
  int n_ack = 0, n_dat = 0, n_fwd = 0, n_unb = 0, n_err = 0;
  int ack_cyc, dat_cyc, fwd_cyc;
  logic [SW-1:0] m_ack_dst, m_dat_dst, m_fwd_src;
  logic [DW-1:0] m_dat_data;
  logic          m_dat_dirty, m_dat_excl, m_owner, m_live;
  logic [2:0]    m_fwd_kind;
  logic [AW-1:0] m_fwd_addr;
  always @(negedge clk) if (!rst) begin
    if (ack_valid) begin n_ack++; m_ack_dst = ack_dst; ack_cyc = cyc; end
    if (dat_valid) begin
      n_dat++; m_dat_dst = dat_dst; m_dat_data = dat_data;
      m_dat_dirty = dat_dirty; m_dat_excl = dat_excl; dat_cyc = cyc;
    end
    if (fwd_valid) begin
      n_fwd++; m_fwd_kind = fwd_kind; m_fwd_addr = fwd_addr; m_fwd_src = fwd_src; fwd_cyc = cyc;
    end
    if (unb_valid) begin n_unb++; m_owner = unb_owner; m_live = unb_live; end
    if (proto_err) n_err++;
  end

  int n_chk = 0, n_bad = 0;
  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 0; rsp_valid = 0;
    repeat (3) step();
    rst = 1'b0;
    step();
  endtask

  task automatic send_req(input logic [2:0] k, input logic sh, input logic [AW-1:0] a,
                          input logic [SW-1:0] s, output int acc);
    int w;
    req_valid = 1; req_kind = k; req_shared = sh; req_addr = a; req_src = s;
    #1;
    w = 0;
    while (!req_ready && w < 200) begin step(); w++; end
    if (w >= 200) chk("R11", "request never accepted", 0, 1);
    step();
    acc = cyc;
    req_valid = 0;
  endtask

  task automatic send_rsp(input bit stale, input bit sh, input bit dt,
                          input logic [SW-1:0] s, input logic [DW-1:0] d);
    rsp_valid = 1; rsp_stale = stale; rsp_shared = sh; rsp_dirty = dt;
    rsp_src = s; rsp_data = d;
    step();
    rsp_valid = 0;
  endtask

  // model of the requirements
  function automatic line_st_t exp_final(line_st_t p, bit vd, bit vs, int oc);
    if (oc == 2) return p;
    if (p == LS_I) return vd ? ((vs || oc == 1) ? LS_O : LS_M) : ((vs || oc == 1) ? LS_S : LS_E);
    if (p == LS_S) return (vd && vs) ? LS_O : LS_S;
    return p;
  endfunction

  function automatic int exp_unb(line_st_t s);
    if (s == LS_M || s == LS_O || s == LS_E) return 3;
    if (s == LS_S) return 1;
    return 0;
  endfunction

  // bring a line from invalid into stable state p with data d
  task automatic install(input line_st_t p, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int acc;
    case (p)
      LS_E: begin send_req(RK_VIC_CLEAN, 0, a, 1, acc); send_rsp(0, 0, 0, 1, d); end
      LS_S: begin send_req(RK_VIC_CLEAN, 1, a, 1, acc); send_rsp(0, 0, 0, 1, d); end
      LS_O: begin send_req(RK_VIC_DIRTY, 1, a, 1, acc); send_rsp(0, 0, 1, 1, d); end
      LS_M: begin send_req(RK_VIC_DIRTY, 0, a, 1, acc); send_rsp(0, 0, 1, 1, d); end
      default: ;
    endcase
    step();
  endtask

  // read-for-modify reveals M/E (data with rights) versus other states (forward)
  task automatic probe(input string rq, input logic [AW-1:0] a, input line_st_t s,
                       input bit dt, input logic [DW-1:0] d);
    int na, nf, acc;
    na = n_dat; nf = n_fwd;
    send_req(RK_READ_MOD, 0, a, 7, acc);
    repeat (RSP_LAT + 1) step();
    if (s == LS_M || s == LS_E) begin
      chk(rq, "modify probe data count", n_dat - na, 1);
      chk(rq, "modify probe excl", m_dat_excl, 1);
      chk("R7", "modify probe dirty", m_dat_dirty, dt);
      chk("R7", "modify probe data", m_dat_data, d);
      chk("R9", "modify probe dst", m_dat_dst, 7);
    end else begin
      chk(rq, "modify probe forward count", n_fwd - nf, 1);
      chk(rq, "modify probe data count", n_dat - na, 0);
    end
  endtask

  bit done = 0;
  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int acc, na, nf, nu, ne, ci;
    line_st_t ps, fs;
    bit pd, fd, vd, vs;
    logic [DW-1:0] d0, d1, fdat;
    string rq;

    // R1: reset state
    do_reset();
    chk("R1", "req_ready after reset", req_ready, 1);
    chk("R1", "valids after reset",
        {ack_valid, dat_valid, fwd_valid, unb_valid, repl_valid, proto_err}, 0);
    nf = n_fwd;
    send_req(RK_READ_MOD, 0, 8'h33, 4'd9, acc);
    chk("R1", "empty cache forwards", n_fwd - nf, 1);
    chk("R10", "forward cycle", fwd_cyc, acc);
    chk("R10", "forward addr", m_fwd_addr, 8'h33);
    chk("R10", "forward kind", m_fwd_kind, RK_READ_MOD);
    chk("R10", "forward src", m_fwd_src, 9);

    // sweep: prior state x victim kind x hint x closing message
    ci = 0;
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 2; k++) begin
        for (int h = 0; h < 2; h++) begin
          for (int oc = 0; oc < 3; oc++) begin
            ps = line_st_t'(p); vd = (k == 0); vs = h[0];
            d0 = 16'h1000 + 16'(ci); d1 = 16'h2000 + 16'(ci);
            pd = (ps == LS_M || ps == LS_O);
            do_reset();
            install(ps, 8'h2D, d0);
            na = n_ack; nu = n_unb;
            send_req(vd ? RK_VIC_DIRTY : RK_VIC_CLEAN, vs, 8'h2D, 4'd5, acc);
            chk("R2", "ack count", n_ack - na, 1);
            chk("R2", "ack dst", m_ack_dst, 5);
            chk("R2", "ack cycle", ack_cyc, acc);
            send_rsp(oc == 2, oc == 1, vd, 4'd5, d1);
            fs = exp_final(ps, vd, vs, oc);
            rq = (oc == 2) ? "R5" : ((ps == LS_I) ? "R3" : "R4");
            chk("R6", "unblock count", n_unb - nu, 1);
            chk("R6", "unblock flags", {m_owner, m_live}, exp_unb(fs));
            if (oc == 2) begin fd = pd; fdat = d0; end
            else begin fd = pd | vd; fdat = d1; end
            probe(rq, 8'h2D, fs, fd, fdat);
            ci++;
          end
        end
      end
    end

    // R8: read hits demote, R10 data latency
    for (int p = 0; p < 5; p++) begin
      ps = line_st_t'(p);
      d0 = 16'h3000 + 16'(p);
      do_reset();
      install(ps, 8'h41, d0);
      na = n_dat; nf = n_fwd;
      send_req((p % 2 == 0) ? RK_READ : RK_READ_SH, 0, 8'h41, 4'd6, acc);
      repeat (RSP_LAT + 1) step();
      if (ps == LS_I) begin
        chk("R9", "read miss forward", n_fwd - nf, 1);
      end else begin
        chk("R8", "read hit data count", n_dat - na, 1);
        chk("R8", "read hit excl", m_dat_excl, 0);
        chk("R8", "read hit data", m_dat_data, d0);
        chk("R8", "read hit dst", m_dat_dst, 6);
        chk("R10", "read data cycle", dat_cyc, acc + RSP_LAT - 1);
        // demoted to O or S: modify probe now forwards
        probe("R8", 8'h41, LS_S, 0, 0);
      end
    end

    // R11: victim into an occupied set
    do_reset();
    install(LS_E, 8'h0A, 16'h4444);
    req_valid = 1; req_kind = RK_VIC_DIRTY; req_shared = 0; req_addr = 8'h1A; req_src = 5;
    step(); step();
    chk("R11", "held victim ready", req_ready, 0);
    chk("R11", "replacement request", repl_valid, 1);
    chk("R11", "replacement addr", repl_addr, 8'h0A);
    req_valid = 0;
    step();
    probe("R9", 8'h0A, LS_E, 0, 16'h4444);
    na = n_ack;
    send_req(RK_VIC_DIRTY, 0, 8'h1A, 4'd5, acc);
    chk("R11", "victim taken once set free", n_ack - na, 1);
    send_rsp(0, 0, 1, 4'd5, 16'h5555);
    step();
    probe("R3", 8'h1A, LS_M, 1, 16'h5555);

    // R12: open wait blocks its set, other sets served in the same cycle as completion
    do_reset();
    install(LS_E, 8'h04, 16'h6666);
    send_req(RK_VIC_CLEAN, 0, 8'h03, 4'd5, acc);
    req_valid = 1; req_kind = RK_READ; req_addr = 8'h23; req_src = 2; #1;
    chk("R12", "same-set read held", req_ready, 0);
    req_kind = RK_VIC_DIRTY; req_addr = 8'h05; #1;
    chk("R12", "second victim held", req_ready, 0);
    req_kind = RK_READ; req_addr = 8'h04; req_src = 9;
    rsp_valid = 1; rsp_stale = 0; rsp_shared = 0; rsp_dirty = 0; rsp_src = 5; rsp_data = 16'hBEEF;
    #1;
    chk("R12", "other-set read ready", req_ready, 1);
    na = n_dat; nu = n_unb;
    step();
    acc = cyc; req_valid = 0; rsp_valid = 0;
    chk("R12", "concurrent unblock count", n_unb - nu, 1);
    chk("R12", "concurrent unblock flags", {m_owner, m_live}, 3);
    repeat (RSP_LAT) step();
    chk("R12", "concurrent read data count", n_dat - na, 1);
    chk("R12", "concurrent read data", m_dat_data, 16'h6666);
    chk("R12", "concurrent read dst", m_dat_dst, 9);
    probe("R12", 8'h03, LS_E, 0, 16'hBEEF);
    probe("R12", 8'h04, LS_S, 0, 0);

    // R13: messages from the wrong sender or with no wait open
    do_reset();
    ne = n_err; nu = n_unb;
    send_rsp(0, 0, 0, 4'd5, 16'h0001);
    step();
    chk("R13", "idle message error", n_err - ne, 1);
    send_req(RK_VIC_CLEAN, 0, 8'h06, 4'd5, acc);
    send_rsp(0, 0, 1, 4'd6, 16'h0002);
    step();
    chk("R13", "wrong sender error", n_err - ne, 2);
    chk("R13", "no unblock on error", n_unb - nu, 0);
    req_valid = 1; req_kind = RK_READ; req_addr = 8'h06; req_src = 2; #1;
    chk("R13", "wait still open", req_ready, 0);
    req_valid = 0;
    send_rsp(0, 0, 0, 4'd5, 16'h0003);
    chk("R13", "right sender closes wait", n_unb - nu, 1);
    step();
    probe("R13", 8'h06, LS_E, 0, 16'h0003);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule